// File: doc/BRIEF.md
# USB IN Endpoint Response Controller

This block decides how a USB device IN endpoint answers each IN token from the host. On every token strobe it looks at the number of bytes waiting in the endpoint FIFO, the configured maximum packet size and a software-owned "transfer done" flag. One cycle later it presents a response code and a byte count: a data packet of a given length, a zero-length packet, or a NAK. The serializer, CRC generator and FIFO storage sit outside this block and act on that response.

The done flag selects the packet policy. While it is 1, software is still loading the FIFO, and only full-size packets leave the endpoint; anything less than a full packet is answered with NAK. When software clears the flag, the endpoint drains the FIFO. It sends full packets while they last, then a short packet, or a zero-length packet if nothing remains. Either of these final packets ends the transfer. The block then sets the flag back to 1 and emits a one-cycle end-of-transfer pulse.

For debug, software can arm a one-shot request that marks the next non-empty data packet for CRC corruption. The request is honoured only while debug mode is enabled. It disarms itself once used, and its register image always reads back as zero.

Top module: `usb_in_resp_ctrl`

## Requirements
- R1: After reset the done flag reads 1, `rsp_valid` and `eot_pulse` are 0, and no CRC corruption is armed.
- R2: While the done flag is 1 and the FIFO count is at least the maximum packet size, a token is answered with code 01 (data) and a length equal to the maximum packet size.
- R3: While the done flag is 1 and the FIFO count is below the maximum packet size (including zero), a token is answered with code 00 (NAK) and length 0.
- R4: While the done flag is 0 and the FIFO holds at least a maximum-size packet, a token is answered with code 01 and the maximum length, and no end-of-transfer occurs: the done flag stays 0.
- R5: While the done flag is 0 and the FIFO holds between 1 and max-1 bytes, a token is answered with code 01 and the FIFO count as length, and this ends the transfer.
- R6: While the done flag is 0 and the FIFO is empty, a token is answered with code 10 (zero-length packet) and length 0, and this ends the transfer.
- R7: `rsp_valid` is 1 exactly in the cycle after a token strobe and 0 otherwise.
- R8: An end-of-transfer raises `eot_pulse` for exactly one cycle, in the same cycle the done flag returns to 1. The hardware set wins over a software write of 0 in the same cycle.
- R9: A CRC request written while debug mode is 1 sets `rsp_crc_bad` on the next data packet of non-zero length only. NAK and zero-length responses leave the request armed.
- R10: A CRC request written while debug mode is 0 has no effect.
- R11: The CRC request register image `crc_req_rdata` always reads 0.
- R12: A software write to the done flag takes effect in the following cycle. A token in the same cycle as the write is judged against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_count | input | CNT_W | Bytes currently held in the IN FIFO |
| max_pkt | input | CNT_W | Configured maximum packet size |
| token_vld | input | 1 | One-cycle strobe: an IN token has arrived |
| sw_done_wr | input | 1 | Software write strobe for the done flag |
| sw_done_wdata | input | 1 | Value written to the done flag |
| debug_en | input | 1 | Debug mode enable |
| crc_req_wr | input | 1 | Software write of 1 to the CRC-error request |
| done_flag | output | 1 | Current done flag |
| crc_req_rdata | output | 1 | Read image of the CRC request (always 0) |
| rsp_valid | output | 1 | Response valid, one cycle after a token |
| rsp_code | output | 2 | 00 NAK, 01 data, 10 zero-length |
| rsp_len | output | CNT_W | Byte count of the data packet, 0 otherwise |
| rsp_crc_bad | output | 1 | This data packet must carry a corrupted CRC |
| eot_pulse | output | 1 | One-cycle end-of-transfer event |

## Verification
The response decision is tried with FIFO counts far above, exactly at, one below and well below the maximum packet size, and with an empty FIFO, each under both values of the done flag. This separates the filling policy from the draining policy and pins the short/full boundary in both. A transfer that ends in a full packet followed by an empty FIFO is driven separately from one ending in a short packet, to tell the zero-length closing packet apart. Software writes are placed in the same cycle as tokens and as end-of-transfer, to expose priority and timing. CRC requests are interleaved with NAK, zero-length and data responses, and with debug mode off, to show which responses consume the request.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;

    typedef enum logic [1:0] {
        RSP_NAK  = 2'b00,
        RSP_DATA = 2'b01,
        RSP_ZLP  = 2'b10
    } rsp_code_e;

endpackage

// File: rtl/usb_in_policy.sv
module usb_in_policy
    import usb_in_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] max_pkt,
    input  logic             done_q,
    output rsp_code_e        code,
    output logic [CNT_W-1:0] len,
    output logic             ends_xfer
);

    logic have_full;
    logic fifo_empty;

    always_comb begin
        have_full  = (fifo_count >= max_pkt);
        fifo_empty = (fifo_count == '0);
        code       = RSP_NAK;
        len        = '0;
        ends_xfer  = 1'b0;
        if (done_q) begin
            // software still loading: full packets only
            if (have_full) begin
                code = RSP_DATA;
                len  = max_pkt;
            end
        end else if (have_full) begin
            code = RSP_DATA;
            len  = max_pkt;
        end else if (!fifo_empty) begin
            code      = RSP_DATA;
            len       = fifo_count;
            ends_xfer = 1'b1;
        end else begin
            code      = RSP_ZLP;
            ends_xfer = 1'b1;
        end
    end

endmodule

// File: rtl/usb_in_done_reg.sv
module usb_in_done_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_wr,
    input  logic sw_wdata,
    input  logic hw_set,
    output logic done_q
);

    logic done_d;

    always_comb begin
        done_d = done_q;
        if (sw_wr) begin
            done_d = sw_wdata;
        end
        if (hw_set) begin
            done_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b1;
        end else begin
            done_q <= done_d;
        end
    end

endmodule

// File: rtl/usb_in_crc_inject.sv
module usb_in_crc_inject (
    input  logic clk,
    input  logic rst_n,
    input  logic debug_en,
    input  logic req_wr,
    input  logic consume,
    output logic armed_q,
    output logic corrupt
);

    logic armed_d;

    always_comb begin
        corrupt = consume && armed_q && debug_en;
        armed_d = armed_q;
        if (!debug_en) begin
            armed_d = 1'b0;
        end else if (req_wr) begin
            armed_d = 1'b1;
        end else if (consume) begin
            armed_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= armed_d;
        end
    end

endmodule

// File: rtl/usb_in_resp_ctrl.sv
module usb_in_resp_ctrl
    import usb_in_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] max_pkt,
    input  logic             token_vld,
    input  logic             sw_done_wr,
    input  logic             sw_done_wdata,
    input  logic             debug_en,
    input  logic             crc_req_wr,
    output logic             done_flag,
    output logic             crc_req_rdata,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code,
    output logic [CNT_W-1:0] rsp_len,
    output logic             rsp_crc_bad,
    output logic             eot_pulse
);

    typedef struct packed {
        logic             vld;
        rsp_code_e        code;
        logic [CNT_W-1:0] len;
        logic             crc_bad;
        logic             eot;
    } rsp_state_t;

    rsp_state_t       st_d, st_q;
    rsp_code_e        pol_code;
    logic [CNT_W-1:0] pol_len;
    logic             pol_ends;
    logic             done_q;
    logic             eot_evt;
    logic             data_nz;
    logic             crc_armed;
    logic             crc_corrupt;

    usb_in_policy #(.CNT_W(CNT_W)) u_policy (
        .fifo_count (fifo_count),
        .max_pkt    (max_pkt),
        .done_q     (done_q),
        .code       (pol_code),
        .len        (pol_len),
        .ends_xfer  (pol_ends)
    );

    usb_in_done_reg u_done (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_wr    (sw_done_wr),
        .sw_wdata (sw_done_wdata),
        .hw_set   (eot_evt),
        .done_q   (done_q)
    );

    usb_in_crc_inject u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .debug_en (debug_en),
        .req_wr   (crc_req_wr),
        .consume  (data_nz),
        .armed_q  (crc_armed),
        .corrupt  (crc_corrupt)
    );

    always_comb begin
        eot_evt    = token_vld && pol_ends;
        data_nz    = token_vld && (pol_code == RSP_DATA) && (pol_len != '0);
        st_d       = '0;
        st_d.vld   = token_vld;
        st_d.code  = token_vld ? pol_code : RSP_NAK;
        st_d.len   = token_vld ? pol_len : '0;
        st_d.crc_bad = crc_corrupt;
        st_d.eot   = eot_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_flag     = done_q;
    assign crc_req_rdata = 1'b0;
    assign rsp_valid     = st_q.vld;
    assign rsp_code      = st_q.code;
    assign rsp_len       = st_q.len;
    assign rsp_crc_bad   = st_q.crc_bad;
    assign eot_pulse     = st_q.eot;

endmodule

// File: rtl/usb_in_resp_chk.sv
module usb_in_resp_chk #(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] fifo_count,
    input logic [CNT_W-1:0] max_pkt,
    input logic             token_vld,
    input logic             done_flag,
    input logic             rsp_valid,
    input logic [1:0]       rsp_code,
    input logic [CNT_W-1:0] rsp_len,
    input logic             rsp_crc_bad,
    input logic             eot_pulse
);

    assert_full_when_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (token_vld && done_flag && fifo_count >= max_pkt)
        |=> (rsp_code == 2'b01 && rsp_len == $past(max_pkt)));

    assert_nak_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (token_vld && done_flag && fifo_count < max_pkt)
        |=> (rsp_code == 2'b00 && rsp_len == '0));

    assert_zlp_on_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (token_vld && !done_flag && fifo_count == '0)
        |=> (rsp_code == 2'b10 && eot_pulse));

    assert_valid_follows_token_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !token_vld |=> !rsp_valid);

    assert_eot_sets_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eot_pulse |-> done_flag);

    assert_eot_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eot_pulse |=> !eot_pulse);

    assert_crc_on_data_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_crc_bad |-> (rsp_valid && rsp_code == 2'b01 && rsp_len != '0));

endmodule

bind usb_in_resp_ctrl usb_in_resp_chk #(.CNT_W(CNT_W)) u_resp_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_count  (fifo_count),
    .max_pkt     (max_pkt),
    .token_vld   (token_vld),
    .done_flag   (done_flag),
    .rsp_valid   (rsp_valid),
    .rsp_code    (rsp_code),
    .rsp_len     (rsp_len),
    .rsp_crc_bad (rsp_crc_bad),
    .eot_pulse   (eot_pulse)
);

// File: tb/usb_in_resp_ctrl_bench.sv
module usb_in_resp_ctrl_bench;

    localparam int CNT_W = 11;
    localparam int MAXP  = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] fifo_count = '0;
    logic [CNT_W-1:0] max_pkt = CNT_W'(MAXP);
    logic             token_vld = 1'b0;
    logic             sw_done_wr = 1'b0;
    logic             sw_done_wdata = 1'b0;
    logic             debug_en = 1'b0;
    logic             crc_req_wr = 1'b0;
    logic             done_flag;
    logic             crc_req_rdata;
    logic             rsp_valid;
    logic [1:0]       rsp_code;
    logic [CNT_W-1:0] rsp_len;
    logic             rsp_crc_bad;
    logic             eot_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    usb_in_resp_ctrl #(.CNT_W(CNT_W)) u_usb_in_resp_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .fifo_count    (fifo_count),
        .max_pkt       (max_pkt),
        .token_vld     (token_vld),
        .sw_done_wr    (sw_done_wr),
        .sw_done_wdata (sw_done_wdata),
        .debug_en      (debug_en),
        .crc_req_wr    (crc_req_wr),
        .done_flag     (done_flag),
        .crc_req_rdata (crc_req_rdata),
        .rsp_valid     (rsp_valid),
        .rsp_code      (rsp_code),
        .rsp_len       (rsp_len),
        .rsp_crc_bad   (rsp_crc_bad),
        .eot_pulse     (eot_pulse)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    // token in one cycle; sample at next negedge (after registering edge)
    task automatic token(input int cnt, input bit wr, input bit wval,
                         input int e_code, input int e_len, input bit e_eot,
                         input bit e_done, input bit e_crc, input string tag);
        @(negedge clk);
        fifo_count    = CNT_W'(cnt);
        token_vld     = 1'b1;
        sw_done_wr    = wr;
        sw_done_wdata = wval;
        @(negedge clk);
        token_vld  = 1'b0;
        sw_done_wr = 1'b0;
        chk_eq({tag, " valid"}, int'(rsp_valid), 1);
        chk_eq({tag, " code"}, int'(rsp_code), e_code);
        chk_eq({tag, " len"}, int'(rsp_len), e_len);
        chk_eq({tag, " eot"}, int'(eot_pulse), int'(e_eot));
        chk_eq({tag, " done"}, int'(done_flag), int'(e_done));
        chk_eq({tag, " crc"}, int'(rsp_crc_bad), int'(e_crc));
    endtask

    task automatic write_done(input bit v);
        @(negedge clk);
        sw_done_wr    = 1'b1;
        sw_done_wdata = v;
        @(negedge clk);
        sw_done_wr = 1'b0;
    endtask

    task automatic crc_request;
        @(negedge clk);
        crc_req_wr = 1'b1;
        @(negedge clk);
        crc_req_wr = 1'b0;
        chk_eq("R11 crc image after write", int'(crc_req_rdata), 0);
    endtask

    task automatic t_reset;
        chk_eq("R1 done after reset", int'(done_flag), 1);
        chk_eq("R1 valid after reset", int'(rsp_valid), 0);
        chk_eq("R1 eot after reset", int'(eot_pulse), 0);
        chk_eq("R11 crc image at reset", int'(crc_req_rdata), 0);
    endtask

    task automatic t_busy;
        token(MAXP, 0, 0, 1, MAXP, 0, 1, 0, "R2 exact max");
        token(200, 0, 0, 1, MAXP, 0, 1, 0, "R2 above max");
        token(MAXP - 1, 0, 0, 0, 0, 0, 1, 0, "R3 one short");
        token(0, 0, 0, 0, 0, 0, 1, 0, "R3 empty");
        @(negedge clk);
        chk_eq("R7 idle after token", int'(rsp_valid), 0);
    endtask

    task automatic t_drain_short;
        write_done(0);
        chk_eq("R12 done cleared", int'(done_flag), 0);
        token(130, 0, 0, 1, MAXP, 0, 0, 0, "R4 full drain");
        token(MAXP + 2, 0, 0, 1, MAXP, 0, 0, 0, "R4 full again");
        token(2, 0, 0, 1, 2, 1, 1, 0, "R5 short ends");
        @(negedge clk);
        chk_eq("R8 eot one cycle", int'(eot_pulse), 0);
        chk_eq("R8 done held", int'(done_flag), 1);
        chk_eq("R7 valid dropped", int'(rsp_valid), 0);
        write_done(0);
        token(MAXP - 1, 0, 0, 1, MAXP - 1, 1, 1, 0, "R5 max minus one");
    endtask

    task automatic t_drain_zlp;
        write_done(0);
        token(MAXP, 0, 0, 1, MAXP, 0, 0, 0, "R4 exact full");
        token(0, 0, 0, 2, 0, 1, 1, 0, "R6 closing zlp");
        write_done(0);
        token(0, 0, 0, 2, 0, 1, 1, 0, "R6 empty transfer");
    endtask

    task automatic t_races;
        write_done(0);
        token(5, 1, 0, 1, 5, 1, 1, 0, "R8 hw set beats sw clear");
        token(5, 1, 0, 0, 0, 0, 0, 0, "R12 token sees old done");
        token(0, 0, 0, 2, 0, 1, 1, 0, "R12 then zlp");
    endtask

    task automatic t_crc;
        debug_en = 1'b1;
        crc_request();
        token(10, 0, 0, 0, 0, 0, 1, 0, "R9 nak keeps request");
        token(MAXP, 0, 0, 1, MAXP, 0, 1, 1, "R9 corrupt next data");
        token(MAXP, 0, 0, 1, MAXP, 0, 1, 0, "R9 one shot");
        crc_request();
        write_done(0);
        token(0, 0, 0, 2, 0, 1, 1, 0, "R9 zlp keeps request");
        token(MAXP, 0, 0, 1, MAXP, 0, 1, 1, "R9 corrupt after zlp");
        debug_en = 1'b0;
        crc_request();
        @(negedge clk);
        debug_en = 1'b1;
        token(MAXP, 0, 0, 1, MAXP, 0, 1, 0, "R10 ignored without debug");
        chk_eq("R11 crc image end", int'(crc_req_rdata), 0);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_busy();
        t_drain_short();
        t_drain_zlp();
        t_races();
        t_crc();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule